// File: doc/BRIEF.md
# Keypad Matrix Debouncer

This block scans a row/column key matrix and debounces what it sees. It pulls one column line low per clock and samples the active-low row lines. After one full pass over the columns it holds a complete snapshot of the matrix, called a frame. A debounce run compares each new frame with a reference frame. The run ends only when enough consecutive frames match that reference without a break. The matching frame then becomes the debounced key state.

A run can start in two ways, set by a mode bit. In automatic mode the block starts a run by itself when a frame differs from the debounced state. In host mode such a difference only pulls the active-low interrupt. The run waits until the host writes the control register.

The debounced keys can be read through a status view filtered by a per-key mask. A pending view collects every completed result with no mask applied. Reading the pending view clears it and releases the interrupt.

Top module: `keypad_debouncer`

## Requirements
- R1: After reset, exactly one column output is low in every cycle. The low column steps 0, 1, … NUM_COLS-1 and then wraps, one step per clock.
- R2: A key at column c and row r is bit c*NUM_ROWS+r of every key vector (status, pending, mask). The bit is 1 when the key is pressed, which shows as that row low while column c is driven.
- R3: In automatic mode (control bit 3 = 1), an idle block starts a debounce run when a completed frame differs from the debounced state.
- R4: In host mode (control bit 3 = 0), a differing frame while idle pulls key_irq_n low and starts no run. A run starts on a control write whose bit 3 is 0. Control writes made during a run neither restart nor stop it.
- R5: Control bits [2:0] hold a code n. A run completes once 2^(n+1) consecutive frames equal the reference. With n=0 that is 2 frames; with n=7 it is 256 frames.
- R6: A frame that differs from the reference becomes the new reference and restarts the count from zero.
- R7: Address 2 reads the debounced keys AND NOT the mask. Address 1 holds the mask, where a 1 hides that key.
- R8: Address 3 (pending) gains, on each completion, the bits of the completed frame. The mask does not affect it, and bits stay set until a read.
- R9: A read of address 3 clears pending and releases key_irq_n. A completion or host-mode difference in the same cycle still sets its bits and the interrupt.
- R10: A completion whose frame has at least one key pressed pulls key_irq_n low.
- R11: After reset: control, mask, status and pending read 0, the block is in host mode with code 0, and key_irq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_n | output | NUM_COLS | Column drive, the active column low |
| rows_n | input | NUM_ROWS | Row sense, low for a pressed key in the driven column |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 3 clears pending) |
| reg_addr | input | 2 | Register select: 0 control, 1 mask, 2 status, 3 pending |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| key_irq_n | output | 1 | Active-low key interrupt |

## Verification
A host read of the pending register can land in the same cycle that a debounce run completes, so the clear and the new bits collide. The bench provokes this by starting a short run and reading pending on every cycle across the whole completion window. One of those reads then meets the completing frame. Each read value and key_irq_n is judged against a behavioural model. In the model the new bits survive the clear and the interrupt stays asserted.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
   localparam int CODE_W   = 3;
   localparam int MAX_EXP  = 1 << CODE_W;
   localparam int AUTO_BIT = CODE_W;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_MASK = 2'd1;
   localparam logic [1:0] ADDR_STAT = 2'd2;
   localparam logic [1:0] ADDR_PEND = 2'd3;

   typedef enum logic {ST_IDLE = 1'b0, ST_SETTLE = 1'b1} settle_state_e;
endpackage

// File: rtl/kpd_col_scanner.sv
module kpd_col_scanner #(
   parameter int NUM_ROWS       = 4,
   parameter int NUM_COLS       = 4,
   parameter bit ROW_ACTIVE_LOW = 1'b1,
   localparam int KEYS          = NUM_ROWS * NUM_COLS,
   localparam int IDX_W         = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_ROWS-1:0] row_sense,
   output logic [NUM_COLS-1:0] col_n,
   output logic [KEYS-1:0]     frame,
   output logic                frame_vld
);
   localparam logic [IDX_W-1:0] LAST_COL = IDX_W'(NUM_COLS - 1);

   logic [IDX_W-1:0]    col_idx;
   logic [KEYS-1:0]     acc_q;
   logic [KEYS-1:0]     acc_next;
   logic [NUM_ROWS-1:0] row_hit;

   generate
      if (ROW_ACTIVE_LOW) begin : g_pol_low
         assign row_hit = ~row_sense;
      end else begin : g_pol_high
         assign row_hit = row_sense;
      end
   endgenerate

   generate
      for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
         assign col_n[c] = (col_idx != IDX_W'(c));
      end
   endgenerate

   always_comb begin
      acc_next = acc_q;
      acc_next[int'(col_idx) * NUM_ROWS +: NUM_ROWS] = row_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_idx   <= '0;
         acc_q     <= '0;
         frame     <= '0;
         frame_vld <= 1'b0;
      end else begin
         acc_q     <= acc_next;
         frame_vld <= (col_idx == LAST_COL);
         if (col_idx == LAST_COL) begin
            frame   <= acc_next;
            col_idx <= '0;
         end else begin
            col_idx <= col_idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/kpd_stability_timer.sv
module kpd_stability_timer
   import kpd_pkg::*;
#(
   parameter int KEYS = 16,
   localparam int CNT_W = MAX_EXP + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [KEYS-1:0]   frame,
   input  logic              frame_vld,
   input  logic [CODE_W-1:0] code,
   input  logic              auto_mode,
   input  logic              host_start,
   output logic              running,
   output logic              done,
   output logic              host_evt,
   output logic [KEYS-1:0]   deb_keys
);
   settle_state_e    state_q;
   logic [KEYS-1:0]  ref_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] period;
   logic             changed;
   logic             start;
   logic             same;

   assign running  = (state_q == ST_SETTLE);
   assign changed  = frame_vld && (frame != deb_keys);
   assign period   = CNT_W'(1) << ({1'b0, code} + 4'd1);
   assign cnt_inc  = cnt_q + 1'b1;
   assign same     = (frame == ref_q);
   assign start    = !running && ((auto_mode && changed) || host_start);
   assign host_evt = !running && !auto_mode && changed;
   assign done     = running && frame_vld && same && (cnt_inc == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ref_q    <= '0;
         cnt_q    <= '0;
         deb_keys <= '0;
      end else if (start) begin
         state_q <= ST_SETTLE;
         ref_q   <= frame;
         cnt_q   <= '0;
      end else if (running && frame_vld) begin
         if (!same) begin
            ref_q <= frame;
            cnt_q <= '0;
         end else if (done) begin
            state_q  <= ST_IDLE;
            deb_keys <= frame;
         end else begin
            cnt_q <= cnt_inc;
         end
      end
   end
endmodule

// File: rtl/kpd_regfile.sv
module kpd_regfile
   import kpd_pkg::*;
#(
   parameter int KEYS   = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [CODE_W-1:0] code,
   output logic              auto_mode,
   output logic              host_start,
   input  logic              done,
   input  logic [KEYS-1:0]   done_keys,
   input  logic              host_evt,
   input  logic [KEYS-1:0]   deb_keys,
   output logic [KEYS-1:0]   pending,
   output logic              key_irq_n
);
   logic [KEYS-1:0] mask_q;
   logic            irq_q;
   logic            wr_ctrl;
   logic            pend_rd;

   assign wr_ctrl    = reg_wr && (reg_addr == ADDR_CTRL);
   assign pend_rd    = reg_rd && (reg_addr == ADDR_PEND);
   assign host_start = wr_ctrl && !reg_wdata[AUTO_BIT];
   assign key_irq_n  = !irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code      <= '0;
         auto_mode <= 1'b0;
         mask_q    <= '0;
         pending   <= '0;
         irq_q     <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            code      <= reg_wdata[CODE_W-1:0];
            auto_mode <= reg_wdata[AUTO_BIT];
         end
         if (reg_wr && (reg_addr == ADDR_MASK)) begin
            mask_q <= reg_wdata[KEYS-1:0];
         end
         pending <= (pend_rd ? '0 : pending) | (done ? done_keys : '0);
         irq_q   <= (pend_rd ? 1'b0 : irq_q) | (done && (|done_keys)) | host_evt;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL: reg_rdata[AUTO_BIT:0] = {auto_mode, code};
         ADDR_MASK: reg_rdata[KEYS-1:0]   = mask_q;
         ADDR_STAT: reg_rdata[KEYS-1:0]   = deb_keys & ~mask_q;
         default:   reg_rdata[KEYS-1:0]   = pending;
      endcase
   end
endmodule

// File: rtl/keypad_debouncer.sv
module keypad_debouncer
   import kpd_pkg::*;
#(
   parameter int NUM_ROWS = 4,
   parameter int NUM_COLS = 4,
   parameter int DATA_W   = 16,
   localparam int KEYS    = NUM_ROWS * NUM_COLS
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [NUM_COLS-1:0] col_n,
   input  logic [NUM_ROWS-1:0] rows_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [1:0]          reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                key_irq_n
);
   generate
      if (NUM_COLS < 2) begin : g_bad_cols
         $error("keypad_debouncer: NUM_COLS must be at least 2");
      end
      if (NUM_ROWS < 1) begin : g_bad_rows
         $error("keypad_debouncer: NUM_ROWS must be at least 1");
      end
      if (DATA_W < KEYS || DATA_W < AUTO_BIT + 1) begin : g_bad_data
         $error("keypad_debouncer: DATA_W too narrow for the key vector");
      end
   endgenerate

   logic [KEYS-1:0]   frame;
   logic              frame_vld;
   logic [CODE_W-1:0] code;
   logic              auto_mode;
   logic              host_start;
   logic              running;
   logic              done;
   logic              host_evt;
   logic [KEYS-1:0]   deb_keys;
   logic [KEYS-1:0]   pending;

   kpd_col_scanner #(
      .NUM_ROWS      (NUM_ROWS),
      .NUM_COLS      (NUM_COLS),
      .ROW_ACTIVE_LOW(1'b1)
   ) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .row_sense(rows_n),
      .col_n    (col_n),
      .frame    (frame),
      .frame_vld(frame_vld)
   );

   kpd_stability_timer #(
      .KEYS(KEYS)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame     (frame),
      .frame_vld (frame_vld),
      .code      (code),
      .auto_mode (auto_mode),
      .host_start(host_start),
      .running   (running),
      .done      (done),
      .host_evt  (host_evt),
      .deb_keys  (deb_keys)
   );

   kpd_regfile #(
      .KEYS  (KEYS),
      .DATA_W(DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .code      (code),
      .auto_mode (auto_mode),
      .host_start(host_start),
      .done      (done),
      .done_keys (frame),
      .host_evt  (host_evt),
      .deb_keys  (deb_keys),
      .pending   (pending),
      .key_irq_n (key_irq_n)
   );
endmodule

// File: rtl/kpd_debouncer_chk.sv
module kpd_debouncer_chk #(
   parameter int NUM_COLS = 4,
   parameter int KEYS     = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_COLS-1:0] col_n,
   input logic                key_irq_n,
   input logic                reg_rd,
   input logic [1:0]          reg_addr,
   input logic [KEYS-1:0]     frame,
   input logic [KEYS-1:0]     pending,
   input logic [KEYS-1:0]     deb_keys,
   input logic                running,
   input logic                done,
   input logic                host_evt,
   input logic                auto_mode,
   input logic                host_start
);
   logic pend_rd;
   assign pend_rd = reg_rd && (reg_addr == 2'd3);

   assert_one_col_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~col_n) == 1);

   assert_host_no_self_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !auto_mode && !host_start) |=> !running);

   assert_deb_only_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(deb_keys));

   assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_rd |=> ((pending & $past(pending)) == $past(pending)));

   assert_read_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_rd && !done && !host_evt) |=> key_irq_n);

   assert_done_raises_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (|frame)) |=> !key_irq_n);
endmodule

bind keypad_debouncer kpd_debouncer_chk #(
   .NUM_COLS(NUM_COLS),
   .KEYS    (KEYS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .col_n     (col_n),
   .key_irq_n (key_irq_n),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .frame     (frame),
   .pending   (pending),
   .deb_keys  (deb_keys),
   .running   (running),
   .done      (done),
   .host_evt  (host_evt),
   .auto_mode (auto_mode),
   .host_start(host_start)
);

// File: tb/keypad_debouncer_tb.sv
`timescale 1ns/1ps
module keypad_debouncer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  col_n;
   logic [3:0]  rows_n;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        key_irq_n;
   logic [15:0] keys = 16'h0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   keypad_debouncer u_dut (
      .clk(clk), .rst_n(rst_n), .col_n(col_n), .rows_n(rows_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .key_irq_n(key_irq_n)
   );

   // keypad model: row r low when key (c,r) pressed and column c is driven low
   always_comb begin
      rows_n = 4'hF;
      for (int c = 0; c < 4; c++)
         if (!col_n[c]) rows_n = rows_n & ~keys[c*4 +: 4];
   end

   // behavioural reference model, updated on every rising edge
   int          m_col = 0;
   logic [15:0] m_acc = 0, m_frame = 0, m_ref = 0, m_deb = 0, m_pend = 0, m_mask = 0;
   logic        m_fdone = 0, m_run = 0, m_irq = 0, m_auto = 0;
   int          m_cnt = 0;
   logic [2:0]  m_code = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_col = 0; m_acc = 0; m_frame = 0; m_ref = 0; m_deb = 0; m_pend = 0;
         m_mask = 0; m_fdone = 0; m_run = 0; m_irq = 0; m_auto = 0; m_cnt = 0; m_code = 0;
      end else begin : step
         logic [15:0] n_acc, n_frame, n_ref, n_deb, n_pend;
         logic        n_fdone, n_run, n_irq, evt, wrc, rdp, fin, hset;
         int          n_cnt, n_col, per;
         per  = 1 << (int'(m_code) + 1);
         evt  = m_fdone && (m_frame != m_deb);
         wrc  = reg_wr && reg_addr == 2'd0;
         rdp  = reg_rd && reg_addr == 2'd3;
         fin  = 0; hset = 0;
         n_ref = m_ref; n_cnt = m_cnt; n_run = m_run; n_deb = m_deb;
         if (!m_run) begin
            hset = !m_auto && evt;
            if ((m_auto && evt) || (wrc && !reg_wdata[3])) begin
               n_run = 1; n_ref = m_frame; n_cnt = 0;
            end
         end else if (m_fdone) begin
            if (m_frame != m_ref) begin n_ref = m_frame; n_cnt = 0; end
            else if (m_cnt + 1 == per) begin fin = 1; n_run = 0; n_deb = m_frame; end
            else n_cnt = m_cnt + 1;
         end
         n_pend = (rdp ? 16'h0 : m_pend) | (fin ? m_frame : 16'h0);
         n_irq  = (rdp ? 1'b0 : m_irq) | (fin && m_frame != 0) | hset;
         n_acc  = m_acc;
         n_acc[m_col*4 +: 4] = keys[m_col*4 +: 4];
         n_frame = m_frame;
         n_fdone = (m_col == 3);
         if (m_col == 3) begin n_frame = n_acc; n_col = 0; end
         else n_col = m_col + 1;
         if (wrc) begin m_code = reg_wdata[2:0]; m_auto = reg_wdata[3]; end
         if (reg_wr && reg_addr == 2'd1) m_mask = reg_wdata;
         m_acc = n_acc; m_frame = n_frame; m_fdone = n_fdone; m_col = n_col;
         m_ref = n_ref; m_cnt = n_cnt; m_run = n_run; m_deb = n_deb;
         m_pend = n_pend; m_irq = n_irq;
      end
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison of column drive (R1) and interrupt (R4/R9/R10)
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R1 col_n", {12'h0, col_n}, {12'h0, ~(4'b0001 << m_col)});
         check("R10 key_irq_n", {15'h0, key_irq_n}, {15'h0, !m_irq});
      end
   end

   task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 0;
   endtask

   task automatic reg_read(input logic [1:0] a, input string tag);
      logic [15:0] exp;
      @(negedge clk);
      reg_rd = 1; reg_addr = a;
      #1;
      case (a)
         2'd0: exp = {12'h0, m_auto, m_code};
         2'd1: exp = m_mask;
         2'd2: exp = m_deb & ~m_mask;
         default: exp = m_pend;
      endcase
      check(tag, reg_rdata, exp);
      @(posedge clk); #1;
      reg_rd = 0;
   endtask

   task automatic read_expect(input logic [1:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk);
      reg_rd = 1; reg_addr = a;
      #1;
      check(tag, reg_rdata, exp);
      @(posedge clk); #1;
      reg_rd = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1;
      // R11 reset state
      read_expect(2'd0, 16'h0, "R11 ctrl");
      read_expect(2'd1, 16'h0, "R11 mask");
      read_expect(2'd2, 16'h0, "R11 status");
      read_expect(2'd3, 16'h0, "R11 pending");
      check("R11 irq", {15'h0, key_irq_n}, 16'h1);

      // R4 host mode: press key (col1,row1) = bit 5; irq but no debounce
      @(negedge clk); keys = 16'h0020;
      idle(40);
      check("R4 irq low", {15'h0, key_irq_n}, 16'h0);
      read_expect(2'd2, 16'h0, "R4 no run status");
      reg_write(2'd0, 16'h0000);             // host start, code 0
      reg_write(2'd0, 16'h0000);             // write during run: ignored
      idle(40);
      read_expect(2'd2, 16'h0020, "R2 R5 status bit5");
      read_expect(2'd3, 16'h0020, "R8 pending bit5");
      read_expect(2'd3, 16'h0000, "R9 pending cleared");
      check("R9 irq released", {15'h0, key_irq_n}, 16'h1);

      // R3 R6 auto mode code 1 with bounce on key 15
      reg_write(2'd0, 16'h0009);
      read_expect(2'd0, 16'h0009, "R5 ctrl readback");
      @(negedge clk); keys = 16'h8021;
      for (int i = 0; i < 8; i++) begin
         idle(6);
         @(negedge clk); keys[15] = ~keys[15];
         reg_read(2'd2, "R6 status during bounce");
      end
      @(negedge clk); keys = 16'h8021;
      idle(60);
      read_expect(2'd2, 16'h8021, "R3 R6 status settled");
      // R7 mask hides, R8 pending does not
      reg_write(2'd1, 16'h0001);
      read_expect(2'd2, 16'h8020, "R7 masked status");
      read_expect(2'd3, 16'h8021, "R8 unmasked pending");
      // release all keys: auto run to empty state, no irq from empty completion
      @(negedge clk); keys = 16'h0;
      idle(60);
      read_expect(2'd2, 16'h0000, "R3 release status");
      reg_read(2'd3, "R9 clear");

      // R9 concurrency: read pending every cycle across a code-0 completion
      reg_write(2'd0, 16'h0008);
      @(negedge clk); keys = 16'h0400;
      for (int i = 0; i < 40; i++) reg_read(2'd3, "R9 read vs completion");
      idle(8);
      reg_read(2'd3, "R9 after window");

      // R5 long period code 7: 256 frames
      reg_write(2'd0, 16'h000F);
      @(negedge clk); keys = 16'h0408;
      idle(900);
      read_expect(2'd2, 16'h0400, "R5 code7 not yet");
      idle(260);
      read_expect(2'd2, 16'h0408, "R5 code7 done");
      reg_read(2'd3, "R8 pending code7");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule